// File: doc/BRIEF.md
# Event Duration and Occurrence Recorder

This block measures how long an external event signal has been asserted and counts how many times it has been asserted. The raw event level first goes through a two-flop synchroniser and a glitch filter. The filter changes its output only after the synchronised level has held a new value for a fixed number of system clocks. The block also takes a one-cycle tick that marks each quarter second.

When the filtered event rises, a 32-bit working time counter is loaded from a stored running total. The counter then advances by one on every tick while the event stays high, and it stops at all-ones. When the event falls, the working value is written back into the stored total and the occurrence count goes up by one.

The occurrence count is a field of parameterised width plus a roll-over flag that acts as its top bit. The field may wrap to zero once, which sets the flag. After that it stops at all-ones. Every filtered edge opens a busy window lasting a set number of ticks, so that a serial interface can refuse access during it. A one-cycle clear strobe from the command logic zeroes the time and count state. The stored values are held in plain registers.

Top module: `etr_event_timer`

## Requirements
- R1: The synchronised event input must differ from the filtered level for FILT_CLKS consecutive clocks before `event_active` follows it; shorter pulses leave `event_active` and all counts unchanged.
- R2: One clock after `event_active` rises, `work_time` equals `total_time`.
- R3: While `event_active` is 1, `work_time` increases by one on each `tick_q` pulse. It is unchanged between ticks.
- R4: `work_time` stops at 32'hFFFF_FFFF and never wraps to zero.
- R5: One clock after `event_active` falls, `total_time` takes the value of `work_time` and `event_count` goes up by one.
- R6: When `event_count` is all-ones and `count_rollover` is 0, the next event ends with `event_count` at 0 and `count_rollover` at 1.
- R7: When `count_rollover` is 1 and `event_count` is all-ones, further events leave both unchanged.
- R8: One clock after any change of `event_active`, `bus_busy` goes to 1. It returns to 0 on the BUSY_TICKS-th `tick_q` after that change.
- R9: A `clear` pulse sets `work_time`, `total_time`, `event_count` and `count_rollover` to zero in the following cycle. It takes priority over counting, loading and storing.
- R10: After reset, `total_time` and `work_time` both equal INIT_TOTAL, `event_count` and `count_rollover` are 0, `event_active` and `bus_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Raw asynchronous event level |
| tick_q | input | 1 | One-cycle quarter-second tick |
| clear | input | 1 | One-cycle strobe that zeroes time and count state |
| event_active | output | 1 | Filtered event level |
| work_time | output | 32 | Working elapsed-time counter |
| total_time | output | 32 | Stored running total of event time |
| event_count | output | CNT_W | Occurrence count field |
| count_rollover | output | 1 | One-shot roll-over flag of the occurrence count |
| bus_busy | output | 1 | Busy window after each filtered event edge |

## Verification
The assertions assume that `tick_q` and `clear` are single-cycle pulses in the clk domain. They also assume that the stored total only changes through this block, so the working counter never moves backwards while the event is held. The bench drives ticks and clears at the falling clock edge, only after the filtered level has settled. Its glitches are kept well shorter than FILT_CLKS. This way every tick lands cleanly inside or outside an event, and the bench model can add random tick counts to random event sequences without any ambiguity about edges.

// File: rtl/etr_pkg.sv
package etr_pkg;
  localparam int TIME_W = 32;
  typedef logic [TIME_W-1:0] etr_time_t;
  localparam etr_time_t TIME_MAX = '1;
endpackage

// File: rtl/etr_glitch_filter.sv
module etr_glitch_filter #(
  parameter int FILT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int FW = $clog2(FILT_CLKS) + 1;
  localparam logic [FW-1:0] LAST = FW'(FILT_CLKS - 1);

  logic          sync_a, sync_b;
  logic          level_q;
  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= raw_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (sync_b == level) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level   <= sync_b;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/etr_time_acc.sv
module etr_time_acc
  import etr_pkg::*;
#(
  parameter etr_time_t INIT_TOTAL = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  logic      rise,
  input  logic      fall,
  input  logic      tick,
  input  logic      clear,
  output etr_time_t work,
  output etr_time_t total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work  <= INIT_TOTAL;
      total <= INIT_TOTAL;
    end else if (clear) begin
      work  <= '0;
      total <= '0;
    end else if (rise) begin
      work <= total;
    end else if (fall) begin
      total <= work;
    end else if (level && tick && work != TIME_MAX) begin
      work <= work + 1'b1;
    end
  end
endmodule

// File: rtl/etr_event_count.sv
module etr_event_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             rollover
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      rollover <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      rollover <= 1'b0;
    end else if (fall) begin
      if (count != CNT_MAX) begin
        count <= count + 1'b1;
      end else if (!rollover) begin
        count    <= '0;
        rollover <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/etr_busy_window.sv
module etr_busy_window #(
  parameter int BUSY_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  input  logic tick,
  output logic busy
);
  localparam int BW = $clog2(BUSY_TICKS) + 1;
  localparam logic [BW-1:0] LAST = BW'(BUSY_TICKS - 1);

  logic [BW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      seen <= '0;
    end else if (edge_seen) begin
      busy <= 1'b1;
      seen <= '0;
    end else if (busy && tick) begin
      if (seen == LAST) begin
        busy <= 1'b0;
        seen <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/etr_event_timer.sv
module etr_event_timer
  import etr_pkg::*;
#(
  parameter int        FILT_CLKS  = 4,
  parameter int        BUSY_TICKS = 1,
  parameter int        CNT_W      = 16,
  parameter etr_time_t INIT_TOTAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic             tick_q,
  input  logic             clear,
  output logic             event_active,
  output logic [31:0]      work_time,
  output logic [31:0]      total_time,
  output logic [CNT_W-1:0] event_count,
  output logic             count_rollover,
  output logic             bus_busy
);
  logic ev_rise, ev_fall;

  etr_glitch_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_in(event_in),
    .level(event_active), .rise(ev_rise), .fall(ev_fall)
  );

  etr_time_acc #(.INIT_TOTAL(INIT_TOTAL)) u_time (
    .clk(clk), .rst_n(rst_n), .level(event_active), .rise(ev_rise),
    .fall(ev_fall), .tick(tick_q), .clear(clear),
    .work(work_time), .total(total_time)
  );

  etr_event_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fall(ev_fall), .clear(clear),
    .count(event_count), .rollover(count_rollover)
  );

  etr_busy_window #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .edge_seen(ev_rise | ev_fall),
    .tick(tick_q), .busy(bus_busy)
  );
endmodule

// File: rtl/etr_event_timer_chk.sv
module etr_event_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_q,
  input logic             clear,
  input logic             event_active,
  input logic [31:0]      work_time,
  input logic [31:0]      total_time,
  input logic [CNT_W-1:0] event_count,
  input logic             count_rollover,
  input logic             bus_busy
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (event_active && !clear) |=> (work_time >= $past(work_time)));

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_active && !clear && work_time == 32'hFFFF_FFFF) |=> (work_time == 32'hFFFF_FFFF));

  assert_wrap_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_rollover) |-> (event_count == '0));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_rollover && event_count == CMAX && !clear) |=> (count_rollover && event_count == CMAX));

  assert_busy_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(event_active) |=> bus_busy);

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (work_time == '0 && total_time == '0 && event_count == '0 && !count_rollover));

  assert_tick_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (event_active && $past(event_active) && !tick_q && !clear) |=> $stable(work_time));
endmodule

bind etr_event_timer etr_event_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .clear(clear),
  .event_active(event_active), .work_time(work_time), .total_time(total_time),
  .event_count(event_count), .count_rollover(count_rollover), .bus_busy(bus_busy)
);

// File: tb/etr_event_timer_test.sv
`timescale 1ns/1ps
module etr_event_timer_test;
  localparam int          FILT  = 4;
  localparam int          BUSYT = 2;
  localparam int          CW    = 4;
  localparam logic [31:0] INIT  = 32'hFFFF_FFF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic event_in = 1'b0, tick_q = 1'b0, clear = 1'b0;
  logic event_active, count_rollover, bus_busy;
  logic [31:0] work_time, total_time;
  logic [CW-1:0] event_count;

  int checks = 0, fails = 0;
  logic [31:0] m_total, m_work;
  logic [CW-1:0] m_cnt;
  logic m_roll;

  always #2.5 clk = ~clk;

  etr_event_timer #(.FILT_CLKS(FILT), .BUSY_TICKS(BUSYT), .CNT_W(CW), .INIT_TOTAL(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .tick_q(tick_q), .clear(clear),
    .event_active(event_active), .work_time(work_time), .total_time(total_time),
    .event_count(event_count), .count_rollover(count_rollover), .bus_busy(bus_busy)
  );

  function automatic logic [31:0] sat_add(logic [31:0] a, int n);
    logic [32:0] s = {1'b0, a} + 33'(n);
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_q = 1'b1;
    @(negedge clk) tick_q = 1'b0;
  endtask

  task automatic set_event(logic v);
    @(negedge clk) event_in = v;
    repeat (FILT + 6) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    m_total = '0; m_work = '0; m_cnt = '0; m_roll = 1'b0;
  endtask

  task automatic run_event(int nticks, bit full);
    set_event(1'b1);
    m_work = m_total;
    if (full) begin
      chk("R2", work_time, m_work);
      chk("R8", {31'd0, bus_busy}, 32'd1);
    end
    for (int i = 0; i < nticks; i++) do_tick();
    m_work = sat_add(m_work, nticks);
    if (full) chk("R3", work_time, m_work);
    set_event(1'b0);
    m_total = m_work;
    if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
    else if (!m_roll) begin m_cnt = '0; m_roll = 1'b1; end
    if (full) begin
      chk("R5 total", total_time, m_total);
      chk("R5 count", 32'(event_count), 32'(m_cnt));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 total", total_time, INIT);
    chk("R10 work", work_time, INIT);
    chk("R10 count", {31'd0, count_rollover} | 32'(event_count), 32'd0);
    chk("R10 flags", {30'd0, event_active, bus_busy}, 32'd0);
    m_total = INIT; m_work = INIT; m_cnt = '0; m_roll = 1'b0;

    // R4: saturation from near all-ones
    run_event(20, 1'b1);
    chk("R4", work_time, 32'hFFFF_FFFF);

    // R8: busy window lasts BUSYT ticks after an edge
    do_clear();
    set_event(1'b1);
    m_work = m_total;
    chk("R8 set", {31'd0, bus_busy}, 32'd1);
    do_tick();
    chk("R8 hold", {31'd0, bus_busy}, 32'd1);
    do_tick();
    chk("R8 drop", {31'd0, bus_busy}, 32'd0);
    m_work = sat_add(m_work, 2);
    set_event(1'b0);
    m_total = m_work; m_cnt = m_cnt + 1'b1;
    chk("R5 total", total_time, m_total);

    // R1: short glitch ignored
    @(negedge clk) event_in = 1'b1;
    @(negedge clk) event_in = 1'b0;
    repeat (FILT + 6) @(negedge clk);
    chk("R1 active", {31'd0, event_active}, 32'd0);
    chk("R1 count", 32'(event_count), 32'(m_cnt));
    do_tick();
    chk("R1 work", work_time, m_total);

    // random events
    for (int e = 0; e < 6; e++) run_event(int'($urandom_range(0, 9)), 1'b1);

    // R9: clear mid-event, counting restarts from zero
    set_event(1'b1);
    do_tick();
    do_clear();
    chk("R9 work", work_time, 32'd0);
    chk("R9 total", total_time, 32'd0);
    chk("R9 count", {31'd0, count_rollover} | 32'(event_count), 32'd0);
    do_tick(); do_tick(); do_tick();
    set_event(1'b0);
    chk("R9 total after", total_time, 32'd3);
    m_total = 32'd3; m_work = 32'd3; m_cnt = 1;

    // R6/R7: wrap once then saturate
    for (int e = 0; e < 14; e++) run_event(0, 1'b0);
    chk("R6 pre", 32'(event_count), 32'hF);
    run_event(0, 1'b0);
    chk("R6 count", 32'(event_count), 32'd0);
    chk("R6 roll", {31'd0, count_rollover}, 32'd1);
    for (int e = 0; e < 15; e++) run_event(0, 1'b0);
    chk("R7 full", 32'(event_count), 32'hF);
    run_event(int'($urandom_range(1, 5)), 1'b0);
    run_event(0, 1'b0);
    chk("R7 count", 32'(event_count), 32'hF);
    chk("R7 roll", {31'd0, count_rollover}, 32'd1);
    chk("R5 total", total_time, m_total);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule